// File: doc/BRIEF.md
# Dual-Channel Serial Register Interface

This block is the write side of the host register interface of a two-channel serial controller. The host issues single byte writes on a small address bus. Each write goes to the control port or the data port of channel A or channel B. Each channel holds sixteen write registers, and the host reaches them indirectly. A control write made while the channel's pointer is zero loads the pointer. The next control write stores into the selected register, and the pointer then falls back to zero.

A control write taken at pointer zero is also decoded as a command. The commands are "point high", which reaches registers 8 to 15, "clear transmit interrupt" and "clear highest interrupt under service". Register 9 is not stored; it triggers a reset of channel B, channel A or both channels. A data-port write loads the channel's transmit holding register, sets its transmit status bits and raises a transmit interrupt. The byte is presented to the serializer only when transmit is enabled. A peek port returns the stored value of any write register.

Top module: `dual_serial_wrport`

## Requirements
- R1: Only `wr_data[7:0]` is used. Address bit 1 selects the control port (0) or the data port (1). Address bits from bit 2 upward give the channel index, where 0 is channel A and 1 is channel B. A write to any other channel index changes nothing.
- R2: While a channel's pointer is 0, a control write loads the pointer from data bits 2:0. While the pointer is non-zero and not 9, a control write returns the pointer to 0 one clock later.
- R3: In a pointer-zero control write, a command field (data bits 5:3) of 3'b001 adds 8 to the loaded pointer.
- R4: A control write with the pointer at 1–8 or 10–15 stores the byte into that register. Registers 0 and 9 always read back as 0.
- R5: A store into register 4, 5, 12 or 13 pulses `param_chg` for that channel for one cycle, in the cycle after the write.
- R6: A control write with the pointer at 9 decodes data bits 7:6. The value 01 resets channel B, 10 resets channel A, 11 resets both channels and 00 resets nothing. Every reset takes effect at the next clock edge.
- R7: When a register-9 write resets only the other channel, the writing channel's pointer stays at 9. With field 00 the pointer returns to 0.
- R8: A data write sets `tx_byte` to the byte, sets `txe` and `all_sent`, and marks a transmit interrupt pending.
- R9: `tx_valid` pulses for one cycle after a data write only if bit 3 of register 5 was set.
- R10: Command 3'b101 clears the transmit pending and in-service flags. Command 3'b111 clears the receive interrupt if it is in service; otherwise it clears the transmit interrupt if that is in service. An idle channel promotes a pending enabled interrupt to in-service one cycle later, and receive is promoted ahead of transmit.
- R11: `irq` is 1 when the transmit interrupt is pending and register 1 bit 1 is set, or when the receive interrupt is pending (set by `rx_req`) and register 1 bit 4 is set.
- R12: A reset, whether from `rst_n` low or from R6, clears the channel's pointer, registers, `tx_byte`, `txe`, `all_sent` and all interrupt flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte address: bit 1 selects the port, bits from 2 up select the channel |
| wr_data | input | BUS_W | Write data; only bits 7:0 are used |
| rx_req | input | 2 | Per-channel receive interrupt request |
| peek_ch | input | 1 | Channel selected by the peek port |
| peek_idx | input | 4 | Register selected by the peek port |
| peek_val | output | 8 | Stored value of the selected register |
| ptr_o | output | 8 | Register pointers; channel A in bits 3:0 |
| tx_byte | output | 16 | Transmit holding registers; channel A in bits 7:0 |
| tx_valid | output | 2 | Byte handed to the serializer |
| param_chg | output | 2 | Line parameters changed |
| irq | output | 2 | Per-channel interrupt |
| txe | output | 2 | Transmit buffer empty status |
| all_sent | output | 2 | All sent status |

## Verification
The bench builds the block with a 4-bit address and a 16-bit data bus. The extra address bit allows writes to channel indices 2 and 3, which must be ignored. The wide bus lets junk in `wr_data[15:8]` show whether it ever reaches a register, `tx_byte` or the reset decode. At every clock a behavioural model predicts the pointers, stored registers, strobes, status bits and interrupts. A long random phase then reaches command and reset combinations, including resets issued from either channel against either channel.

// File: rtl/ser_pkg.sv
// Shared constants and encodings for the dual-channel serial write interface.
// Assumes exactly two channels of sixteen byte-wide write registers.
package ser_pkg;
    localparam int BYTE_W   = 8;
    localparam int REG_N    = 16;
    localparam int PTR_W    = $clog2(REG_N);
    localparam int NCH      = 2;
    localparam int TXEN_BIT = 3;
    localparam int TXIE_BIT = 1;
    localparam int RXIE_BIT = 4;

    localparam logic [PTR_W-1:0] REG_INTEN = 4'd1;
    localparam logic [PTR_W-1:0] REG_TXCTL = 4'd5;
    localparam logic [PTR_W-1:0] REG_MRST  = 4'd9;

    // command field carried in data bits 5:3 of a pointer-zero write
    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_HIGH    = 3'd1,
        CMD_CLR_TX  = 3'd5,
        CMD_CLR_IUS = 3'd7
    } cmd_e;

    // reset field carried in data bits 7:6 of a register-9 write
    typedef enum logic [1:0] {
        RST_NONE = 2'd0,
        RST_B    = 2'd1,
        RST_A    = 2'd2,
        RST_ALL  = 2'd3
    } rst_e;

    // registers whose store means the line parameters changed
    function automatic logic is_param_reg(input logic [PTR_W-1:0] r);
        return (r == 4'd4) || (r == 4'd5) || (r == 4'd12) || (r == 4'd13);
    endfunction
endpackage

// File: rtl/ser_wr_decode.sv
// Address decoder: turns one host write into per-channel control or data
// strobes and extracts the byte lane. Assumes ADDR_W >= 3; channel
// indices beyond NCH match no channel, so such writes are dropped.
module ser_wr_decode
    import ser_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int BUS_W  = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [NCH-1:0]    ctl_we,
    output logic [NCH-1:0]    dat_we,
    output logic [BYTE_W-1:0] wr_byte
);
    localparam int SEL_W = ADDR_W - 2;

    logic [SEL_W-1:0] sel;
    logic             unused_bits;

    // byte lane and channel field
    assign wr_byte     = wr_data[BYTE_W-1:0];
    assign sel         = wr_addr[ADDR_W-1:2];
    assign unused_bits = ^{wr_addr[0], wr_data};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_hit
        // one strobe per channel and port
        assign ctl_we[ch] = wr_en && (sel == SEL_W'(ch)) && !wr_addr[1];
        assign dat_we[ch] = wr_en && (sel == SEL_W'(ch)) &&  wr_addr[1];
    end
endmodule

// File: rtl/ser_chan_regs.sv
// One serial channel: the register pointer, the command decoder, the sixteen
// write registers, transmit status and interrupt state. Assumes at most one
// of ctl_we/dat_we per cycle; chan_rst (from either channel's register-9
// decode) overrides everything at the next edge.
module ser_chan_regs
    import ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              dat_we,
    input  logic [BYTE_W-1:0] din,
    input  logic              chan_rst,
    input  logic              rx_req,
    input  logic [PTR_W-1:0]  peek_idx,
    output logic [PTR_W-1:0]  ptr,
    output logic [BYTE_W-1:0] peek_val,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_valid,
    output logic              param_chg,
    output logic              irq,
    output logic              txe,
    output logic              all_sent,
    output logic [1:0]        rst_cmd
);
    logic [BYTE_W-1:0] wregs [REG_N];
    logic              tx_pend, rx_pend, tx_ius, rx_ius;
    logic              tx_ie, rx_ie, tx_en;

    // enables taken from stored registers
    assign tx_ie = wregs[REG_INTEN][TXIE_BIT];
    assign rx_ie = wregs[REG_INTEN][RXIE_BIT];
    assign tx_en = wregs[REG_TXCTL][TXEN_BIT];

    // reset request raised toward the top-level reset combiner
    assign rst_cmd  = (ctl_we && ptr == REG_MRST) ? din[7:6] : RST_NONE;
    // shared interrupt line and register peek
    assign irq      = (tx_pend && tx_ie) || (rx_pend && rx_ie);
    assign peek_val = wregs[peek_idx];

    // register state, command decoding and interrupt bookkeeping
    always_ff @(posedge clk) begin
        tx_valid  <= 1'b0;
        param_chg <= 1'b0;
        if (!rst_n || chan_rst) begin
            for (int i = 0; i < REG_N; i++) wregs[i] <= '0;
            ptr      <= '0;
            tx_byte  <= '0;
            txe      <= 1'b0;
            all_sent <= 1'b0;
            tx_pend  <= 1'b0;
            rx_pend  <= 1'b0;
            tx_ius   <= 1'b0;
            rx_ius   <= 1'b0;
        end else begin
            if (!rx_ius && !tx_ius) begin
                if (rx_pend && rx_ie)      rx_ius <= 1'b1;
                else if (tx_pend && tx_ie) tx_ius <= 1'b1;
            end
            if (rx_req) rx_pend <= 1'b1;
            if (dat_we) begin
                tx_byte  <= din;
                txe      <= 1'b1;
                all_sent <= 1'b1;
                tx_pend  <= 1'b1;
                tx_valid <= tx_en;
            end
            if (ctl_we) begin
                if (ptr == '0) begin
                    ptr <= {din[5:3] == CMD_HIGH, din[2:0]};
                    if (din[5:3] == CMD_CLR_TX) begin
                        tx_pend <= 1'b0;
                        tx_ius  <= 1'b0;
                    end else if (din[5:3] == CMD_CLR_IUS) begin
                        if (rx_ius) begin
                            rx_pend <= 1'b0;
                            rx_ius  <= 1'b0;
                        end else if (tx_ius) begin
                            tx_pend <= 1'b0;
                            tx_ius  <= 1'b0;
                        end
                    end
                end else if (ptr == REG_MRST) begin
                    if (din[7:6] == RST_NONE) ptr <= '0;
                end else begin
                    wregs[ptr] <= din;
                    param_chg  <= is_param_reg(ptr);
                    ptr        <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/dual_serial_wrport.sv
// Top of the dual-channel serial write interface: decodes host writes,
// runs two channel register blocks and combines their register-9 reset
// requests into per-channel reset strobes. Assumes synchronous active-low
// reset and one write per clock.
module dual_serial_wrport
    import ser_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [1:0]        rx_req,
    input  logic              peek_ch,
    input  logic [3:0]        peek_idx,
    output logic [7:0]        peek_val,
    output logic [7:0]        ptr_o,
    output logic [15:0]       tx_byte,
    output logic [1:0]        tx_valid,
    output logic [1:0]        param_chg,
    output logic [1:0]        irq,
    output logic [1:0]        txe,
    output logic [1:0]        all_sent
);
    logic [NCH-1:0]    ctl_we, dat_we, chan_rst;
    logic [BYTE_W-1:0] wr_byte;
    logic [BYTE_W-1:0] pv [NCH];
    logic [1:0]        rc [NCH];
    logic [1:0]        rst_any;

    ser_wr_decode #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctl_we  (ctl_we),
        .dat_we  (dat_we),
        .wr_byte (wr_byte)
    );

    // only the addressed channel can raise a request, so OR is enough
    assign rst_any     = rc[0] | rc[1];
    assign chan_rst[0] = (rst_any == RST_A) || (rst_any == RST_ALL);
    assign chan_rst[1] = (rst_any == RST_B) || (rst_any == RST_ALL);
    // peek selection across channels
    assign peek_val    = pv[peek_ch];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        ser_chan_regs u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl_we    (ctl_we[ch]),
            .dat_we    (dat_we[ch]),
            .din       (wr_byte),
            .chan_rst  (chan_rst[ch]),
            .rx_req    (rx_req[ch]),
            .peek_idx  (peek_idx),
            .ptr       (ptr_o[ch*PTR_W +: PTR_W]),
            .peek_val  (pv[ch]),
            .tx_byte   (tx_byte[ch*BYTE_W +: BYTE_W]),
            .tx_valid  (tx_valid[ch]),
            .param_chg (param_chg[ch]),
            .irq       (irq[ch]),
            .txe       (txe[ch]),
            .all_sent  (all_sent[ch]),
            .rst_cmd   (rc[ch])
        );
    end
endmodule

// File: rtl/ser_wr_checker.sv
// Temporal checks on the port behaviour of dual_serial_wrport, attached by
// bind. Looks only at the top-level ports, mostly from channel A's side.
module ser_wr_checker #(
    parameter int ADDR_W = 3,
    parameter int BUS_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [BUS_W-1:0]  wr_data,
    input logic [7:0]        ptr_o,
    input logic [1:0]        tx_valid,
    input logic [1:0]        param_chg,
    input logic [1:0]        txe,
    input logic [1:0]        all_sent
);
    logic       ctl0, dat0;
    logic [3:0] p0;
    logic       unused_chk;

    assign ctl0 = wr_en && !wr_addr[1] && (wr_addr[ADDR_W-1:2] == '0);
    assign dat0 = wr_en &&  wr_addr[1] && (wr_addr[ADDR_W-1:2] == '0);
    assign p0   = ptr_o[3:0];
    assign unused_chk = ^{tx_valid[1], param_chg[1], wr_addr[0], wr_data};

    assert_ptr_return_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl0 && p0 != 4'd0 && p0 != 4'd9) |=> (ptr_o[3:0] == 4'd0));

    assert_point_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl0 && p0 == 4'd0 && wr_data[5:3] == 3'd1) |=> ptr_o[3]);

    assert_param_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl0 && (p0 == 4'd4 || p0 == 4'd5 || p0 == 4'd12 || p0 == 4'd13)) |=> param_chg[0]);

    assert_dev_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl0 && p0 == 4'd9 && wr_data[7:6] == 2'b11) |=> (ptr_o == 8'd0 && txe == 2'b00 && all_sent == 2'b00));

    assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl0 && p0 == 4'd9 && wr_data[7:6] == 2'b01) |=> (ptr_o[3:0] == 4'd9));

    assert_tx_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dat0 |=> (txe[0] && all_sent[0]));

    assert_tx_valid_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid[0] |-> $past(dat0));
endmodule

bind dual_serial_wrport ser_wr_checker #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ptr_o     (ptr_o),
    .tx_valid  (tx_valid),
    .param_chg (param_chg),
    .txe       (txe),
    .all_sent  (all_sent)
);

// File: tb/tb_dual_serial_wrport.sv
`timescale 1ns/1ps
// Bench: a behavioural model predicts every output after each clock, and
// directed checks pin down the pointer, command and reset corner cases.
module tb_dual_serial_wrport;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rx_req = '0;
    logic        peek_ch = 1'b0;
    logic [3:0]  peek_idx = '0;
    logic [7:0]  peek_val, ptr_o;
    logic [15:0] tx_byte;
    logic [1:0]  tx_valid, param_chg, irq, txe, all_sent;

    int checks = 0, errors = 0, nstep = 0;
    bit done = 1'b0;

    // model state
    int m_ptr [2];
    int m_w   [2][16];
    int m_txb [2];
    bit m_txe [2], m_sent [2], m_tp [2], m_rp [2], m_ti [2], m_ri [2], m_txv [2], m_par [2];

    always #2.5 clk = ~clk;

    dual_serial_wrport #(.ADDR_W(4), .BUS_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rx_req(rx_req), .peek_ch(peek_ch), .peek_idx(peek_idx), .peek_val(peek_val),
        .ptr_o(ptr_o), .tx_byte(tx_byte), .tx_valid(tx_valid), .param_chg(param_chg),
        .irq(irq), .txe(txe), .all_sent(all_sent)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear(input int ch);
        m_ptr[ch] = 0; m_txb[ch] = 0;
        for (int i = 0; i < 16; i++) m_w[ch][i] = 0;
        m_txe[ch] = 0; m_sent[ch] = 0; m_tp[ch] = 0; m_rp[ch] = 0;
        m_ti[ch] = 0; m_ri[ch] = 0; m_txv[ch] = 0; m_par[ch] = 0;
    endtask

    // advance the model by one clock with the inputs that were applied
    task automatic model_step();
        int c, b, mask, cmd;
        bit ctl, dat, o_ri, o_ti;
        b   = int'(wr_data[7:0]);
        c   = int'(wr_addr[3:2]);
        ctl = wr_en && !wr_addr[1] && c < 2;
        dat = wr_en &&  wr_addr[1] && c < 2;
        mask = 0;
        if (ctl && m_ptr[c] == 9) begin
            case (b >> 6)
                1: mask = 2;
                2: mask = 1;
                3: mask = 3;
                default: mask = 0;
            endcase
        end
        for (int ch = 0; ch < 2; ch++) begin
            if (!rst_n || mask[ch]) begin
                model_clear(ch);
                continue;
            end
            m_txv[ch] = 0; m_par[ch] = 0;
            o_ri = m_ri[ch]; o_ti = m_ti[ch];
            if (!o_ri && !o_ti) begin
                if (m_rp[ch] && m_w[ch][1][4]) m_ri[ch] = 1;
                else if (m_tp[ch] && m_w[ch][1][1]) m_ti[ch] = 1;
            end
            if (rx_req[ch]) m_rp[ch] = 1;
            if (dat && c == ch) begin
                m_txb[ch] = b; m_txe[ch] = 1; m_sent[ch] = 1; m_tp[ch] = 1;
                m_txv[ch] = m_w[ch][5][3];
            end
            if (ctl && c == ch) begin
                if (m_ptr[ch] == 0) begin
                    cmd = (b >> 3) & 7;
                    m_ptr[ch] = (b & 7) + ((cmd == 1) ? 8 : 0);
                    if (cmd == 5) begin
                        m_tp[ch] = 0; m_ti[ch] = 0;
                    end else if (cmd == 7) begin
                        if (o_ri) begin m_rp[ch] = 0; m_ri[ch] = 0; end
                        else if (o_ti) begin m_tp[ch] = 0; m_ti[ch] = 0; end
                    end
                end else if (m_ptr[ch] == 9) begin
                    if ((b >> 6) == 0) m_ptr[ch] = 0;
                end else begin
                    m_w[ch][m_ptr[ch]] = b;
                    m_par[ch] = (m_ptr[ch] == 4 || m_ptr[ch] == 5 || m_ptr[ch] == 12 || m_ptr[ch] == 13);
                    m_ptr[ch] = 0;
                end
            end
        end
    endtask

    // compare every output with the model
    task automatic compare_all();
        for (int ch = 0; ch < 2; ch++) begin
            chk("R2 pointer", int'(ptr_o[ch*4 +: 4]), m_ptr[ch]);
            chk("R1 tx_byte", int'(tx_byte[ch*8 +: 8]), m_txb[ch]);
            chk("R8 txe", int'(txe[ch]), int'(m_txe[ch]));
            chk("R8 all_sent", int'(all_sent[ch]), int'(m_sent[ch]));
            chk("R9 tx_valid", int'(tx_valid[ch]), int'(m_txv[ch]));
            chk("R5 param_chg", int'(param_chg[ch]), int'(m_par[ch]));
            chk("R11 irq", int'(irq[ch]),
                int'((m_tp[ch] && m_w[ch][1][1]) || (m_rp[ch] && m_w[ch][1][4])));
        end
        chk("R4 peek", int'(peek_val), m_w[peek_ch][peek_idx]);
    endtask

    task automatic step(input bit we, input logic [3:0] a, input logic [15:0] d, input logic [1:0] rx);
        wr_en = we; wr_addr = a; wr_data = d; rx_req = rx;
        peek_ch = nstep[0]; peek_idx = 4'(nstep >> 1);
        nstep++;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic ctl(input int ch, input int v);
        step(1'b1, 4'(ch << 2), {8'hC3, 8'(v)}, 2'b00);
    endtask
    task automatic dat(input int ch, input int v);
        step(1'b1, 4'((ch << 2) | 2), {8'h3C, 8'(v)}, 2'b00);
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 4'd0, 16'd0, 2'b00);
    endtask

    // watchdog
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_clear(0); model_clear(1);
        @(negedge clk);
        idle(3);
        rst_n = 1'b1;
        // R12: state after reset
        chk("R12 ptr after reset", int'(ptr_o), 0);
        chk("R12 txe after reset", int'(txe), 0);
        chk("R12 irq after reset", int'(irq), 0);

        // R2 pointer load and auto-return, R4 store
        ctl(0, 8'h01);
        chk("R2 pointer loaded", int'(ptr_o[3:0]), 1);
        ctl(0, 8'h12);
        chk("R2 pointer returned", int'(ptr_o[3:0]), 0);
        // R3 point high: ptr 5 + 8
        ctl(0, 8'h0D);
        chk("R3 point high", int'(ptr_o[3:0]), 13);
        ctl(0, 8'h55);
        chk("R5 strobe on reg 13", int'(param_chg[0]), 1);
        // enable transmit on channel A
        ctl(0, 8'h05);
        ctl(0, 8'h08);
        dat(0, 8'h5A);
        chk("R9 tx_valid enabled", int'(tx_valid[0]), 1);
        chk("R1 tx_byte low lane", int'(tx_byte[7:0]), 8'h5A);
        chk("R11 irq from tx", int'(irq[0]), 1);
        dat(1, 8'h33);
        chk("R9 tx_valid disabled", int'(tx_valid[1]), 0);
        // R10 clear transmit interrupt
        ctl(0, 8'h28);
        chk("R10 clear tx", int'(irq[0]), 0);
        // R10 in-service ordering: tx in service first, then rx
        dat(0, 8'h11);
        idle(1);
        step(1'b0, 4'd0, 16'd0, 2'b01);
        ctl(0, 8'h38);
        chk("R10 clear tx in service, rx pending", int'(irq[0]), 1);
        idle(1);
        ctl(0, 8'h38);
        chk("R10 clear rx in service", int'(irq[0]), 0);
        // R1 out-of-range channel ignored
        step(1'b1, 4'b1000, 16'h0001, 2'b00);
        step(1'b1, 4'b1100, 16'h0003, 2'b00);
        chk("R1 out-of-range ignored", int'(ptr_o), 0);
        // R6/R7 reset B from channel A
        ctl(1, 8'h03); ctl(1, 8'h77);
        ctl(0, 8'h09);
        ctl(0, 8'h40);
        chk("R6 reset B clears B", int'(ptr_o[7:4]), 0);
        chk("R7 A pointer held", int'(ptr_o[3:0]), 9);
        ctl(0, 8'h00);
        chk("R7 field 00 returns pointer", int'(ptr_o[3:0]), 0);
        // R6/R7 reset A from channel B
        ctl(1, 8'h09);
        ctl(1, 8'h80);
        chk("R6 reset A clears A txe", int'(txe[0]), 0);
        chk("R7 B pointer held", int'(ptr_o[7:4]), 9);
        ctl(1, 8'h00);
        // R6 full reset
        dat(0, 8'h01); dat(1, 8'h02);
        ctl(0, 8'h09);
        ctl(0, 8'hC0);
        chk("R6 full reset status", int'({txe, all_sent}), 0);
        chk("R12 full reset tx_byte", int'(tx_byte), 0);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [3:0]  a;
            logic [15:0] d;
            a = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 3) == 0) a[3] = 1'b0;
            d = 16'($urandom);
            if ($urandom_range(0, 7) == 0) d[7:6] = 2'b00;
            step(($urandom_range(0, 3) != 0), a, d, 2'($urandom_range(0, 3) == 0 ? $urandom : 0));
        end
        // R12: external reset in mid-run
        rst_n = 1'b0;
        idle(1);
        rst_n = 1'b1;
        chk("R12 external reset", int'({ptr_o, txe, irq}), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule